// File: doc/BRIEF.md
# Branch Target Predictor with Static Fallback

This block sits next to the fetch address of a processor front end and proposes the address to fetch next. Every valid fetch looks up a direct-mapped table of branches that have been resolved before. A matching entry whose 2-bit saturating counter leans taken supplies the target it remembered. A matching entry that leans not-taken sends fetch to the next word. When no entry matches and the decoder marks the fetched word as a branch, the sign of the branch's word offset decides the direction: backward branches are predicted taken and forward ones not taken.

The block also forms the architectural branch target itself. It takes the 24-bit signed word offset, scales it to bytes, and adds it to the branch address plus 8. This covers roughly plus or minus 32 MB, with wrap-around modulo 2^32. A resolve port reports each branch's real outcome and taken-target. The table is trained from that port. An entry is overwritten only when a branch with a different tag resolves at its index. Entries never age out. Flushing the pipeline on a misprediction is left to the surrounding logic.

A prediction appears one clock after the fetch that asked for it. All addresses are handled as word addresses, so bits [1:0] of the fetch PC, the resolve PC and the resolve target are ignored, and every address the block drives ends in 2'b00.

Top module: `branch_tgt_pred`

## Requirements
- R1: While reset is high, and on the first clock after it, pred_valid is 0. Reset marks all 128 table entries invalid, so the first lookup at any index misses.
- R2: pred_valid is 1 exactly one clock after a cycle with fetch_valid high, and 0 one clock after a cycle with fetch_valid low. All other outputs describe that earlier fetch.
- R3: A lookup uses index fetch_pc[8:2] and tag fetch_pc[31:9]. It hits only when the entry at that index is valid and its stored tag equals the fetch tag. A hit drives pred_src = 1.
- R4: On a hit, the entry's counter (0..3) predicts taken when it is 2 or 3. pred_next_pc is then the stored target; otherwise pred_next_pc is fetch_pc[31:2]*4 + 4. On a resolve that matches the entry, the counter moves up by one if the branch was taken and down by one if not, saturating at 3 and at 0.
- R5: A resolve that finds its index invalid or holding another tag allocates the entry. It writes the tag and rsv_target, and the counter starts at 2 if the branch was taken and at 1 if not.
- R6: An entry changes only when a resolve targets its own index. A resolve with another tag at the same index replaces it, and entries at other indices keep their state.
- R7: On a miss with fetch_is_br = 1, pred_src = 2. The predicted direction is taken exactly when fetch_off[23] = 1; a taken prediction sends fetch to br_target and a not-taken one to the next word.
- R8: br_target = fetch_pc[31:2]*4 + 8 + sign_extend(fetch_off)*4, modulo 2^32.
- R9: On a miss with fetch_is_br = 0, pred_src = 0, pred_taken = 0 and pred_next_pc = fetch_pc[31:2]*4 + 4, modulo 2^32.
- R10: When a resolve and a lookup reach the same index in the same clock, the lookup reports the entry as it was before that resolve. The update is visible to the next lookup.
- R11: pred_next_pc[1:0] and br_target[1:0] are always 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_pc | input | 32 | Fetch address; bits [1:0] ignored |
| fetch_is_br | input | 1 | Decoder flags the fetched word as a branch |
| fetch_off | input | 24 | Signed word offset of that branch |
| rsv_valid | input | 1 | A branch outcome is reported this cycle |
| rsv_pc | input | 32 | Address of the resolved branch |
| rsv_taken | input | 1 | Resolved branch was taken |
| rsv_target | input | 32 | Taken-target of the resolved branch |
| pred_valid | output | 1 | A prediction for the previous cycle's fetch is present |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Prediction direction |
| pred_src | output | 2 | 0 sequential, 1 table hit, 2 static sign rule |
| br_target | output | 32 | Target computed from the fetched offset |

## Verification
A corrupted valid bit, tag or counter stays hidden until the next fetch to that index. It then shows one clock later as a wrong pred_src, a flipped pred_taken or a wrong pred_next_pc. The bench therefore looks up every index after filling the table. It walks a counter through both saturation points and aliases two tags onto one index. It also reads and writes one index in the same clock, to separate read-before-write from write-first. A long mixed phase that draws from a small tag pool keeps entries colliding, so a lost or misdirected update appears at the ports within a few lookups.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_TABLE  = 2'd1,
    SRC_STATIC = 2'd2
  } pred_src_e;

  // saturating 2-bit history step
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic tk);
    logic [1:0] r;
    if (tk) r = (c == 2'd3) ? c : c + 2'd1;
    else    r = (c == 2'd0) ? c : c - 2'd1;
    return r;
  endfunction

  // counter value for a freshly allocated entry
  function automatic logic [1:0] ctr_init(input logic tk);
    return tk ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/bpred_tag_store.sv
module bpred_tag_store #(
  parameter int IDX_W = 7,
  parameter int TAG_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             upd_taken,
  output logic             lk_valid_q,
  output logic [TAG_W-1:0] lk_tag_q,
  output logic [1:0]       lk_ctr_q
);
  import bpred_pkg::*;

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tags [ENTRIES];
  logic [1:0]         ctrs [ENTRIES];

  logic       upd_match;
  logic [1:0] upd_ctr;

  // resolve side: read-modify-write in one cycle
  always_comb begin
    upd_match = vld[upd_idx] && (tags[upd_idx] == upd_tag);
    upd_ctr   = upd_match ? ctr_step(ctrs[upd_idx], upd_taken) : ctr_init(upd_taken);
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (upd_en) vld[upd_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) lk_valid_q <= 1'b0;
    else if (lk_en) lk_valid_q <= vld[lk_idx];
  end

  // nonblocking write and read in the same block give read-before-write
  always_ff @(posedge clk) begin
    if (upd_en) begin
      tags[upd_idx] <= upd_tag;
      ctrs[upd_idx] <= upd_ctr;
    end
    if (lk_en) begin
      lk_tag_q <= tags[lk_idx];
      lk_ctr_q <= ctrs[lk_idx];
    end
  end

endmodule

// File: rtl/bpred_target_ram.sv
module bpred_target_ram #(
  parameter int AW = 7,
  parameter int DW = 30
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/bpred_static_calc.sv
module bpred_static_calc #(
  parameter int WA_W  = 30,
  parameter int OFF_W = 24
) (
  input  logic [WA_W-1:0]  pc_w,
  input  logic [OFF_W-1:0] off,
  output logic [WA_W-1:0]  tgt_w,
  output logic             backward
);
  localparam int EXT_W = WA_W - OFF_W;
  localparam logic [WA_W-1:0] PIPE_WORDS = WA_W'(2);

  logic [WA_W-1:0] off_ext;

  always_comb begin
    off_ext  = {{EXT_W{off[OFF_W-1]}}, off};
    tgt_w    = pc_w + PIPE_WORDS + off_ext;
    backward = off[OFF_W-1];
  end

endmodule

// File: rtl/branch_tgt_pred.sv
module branch_tgt_pred #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7,
  parameter int OFF_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              fetch_is_br,
  input  logic [OFF_W-1:0]  fetch_off,
  input  logic              rsv_valid,
  input  logic [ADDR_W-1:0] rsv_pc,
  input  logic              rsv_taken,
  input  logic [ADDR_W-1:0] rsv_target,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_next_pc,
  output logic              pred_taken,
  output logic [1:0]        pred_src,
  output logic [ADDR_W-1:0] br_target
);
  import bpred_pkg::*;

  localparam int WA_W  = ADDR_W - 2;
  localparam int TAG_W = WA_W - IDX_W;

  logic [WA_W-1:0] f_pcw, r_pcw, r_tgtw;
  logic            unused_lsbs;

  assign f_pcw       = fetch_pc[ADDR_W-1:2];
  assign r_pcw       = rsv_pc[ADDR_W-1:2];
  assign r_tgtw      = rsv_target[ADDR_W-1:2];
  assign unused_lsbs = ^{fetch_pc[1:0], rsv_pc[1:0], rsv_target[1:0]};

  // lookup stage registers
  logic             s1_valid, s1_br;
  logic [WA_W-1:0]  s1_pcw;
  logic [OFF_W-1:0] s1_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_br    <= 1'b0;
      s1_pcw   <= '0;
      s1_off   <= '0;
    end else begin
      s1_valid <= fetch_valid;
      if (fetch_valid) begin
        s1_br  <= fetch_is_br;
        s1_pcw <= f_pcw;
        s1_off <= fetch_off;
      end
    end
  end

  logic             e_valid;
  logic [TAG_W-1:0] e_tag;
  logic [1:0]       e_ctr;
  logic [WA_W-1:0]  e_tgtw;

  bpred_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk        (clk),
    .rst        (rst),
    .lk_en      (fetch_valid),
    .lk_idx     (f_pcw[IDX_W-1:0]),
    .upd_en     (rsv_valid),
    .upd_idx    (r_pcw[IDX_W-1:0]),
    .upd_tag    (r_pcw[WA_W-1:IDX_W]),
    .upd_taken  (rsv_taken),
    .lk_valid_q (e_valid),
    .lk_tag_q   (e_tag),
    .lk_ctr_q   (e_ctr)
  );

  bpred_target_ram #(.AW(IDX_W), .DW(WA_W)) tgt_i (
    .clk   (clk),
    .we    (rsv_valid),
    .waddr (r_pcw[IDX_W-1:0]),
    .wdata (r_tgtw),
    .re    (fetch_valid),
    .raddr (f_pcw[IDX_W-1:0]),
    .rdata (e_tgtw)
  );

  logic [WA_W-1:0] st_tgtw;
  logic            st_back;

  bpred_static_calc #(.WA_W(WA_W), .OFF_W(OFF_W)) calc_i (
    .pc_w     (s1_pcw),
    .off      (s1_off),
    .tgt_w    (st_tgtw),
    .backward (st_back)
  );

  logic            hit;
  logic [WA_W-1:0] seq_w, nxt_w;
  pred_src_e       src;
  logic            tk;

  always_comb begin
    hit   = e_valid && (e_tag == s1_pcw[WA_W-1:IDX_W]);
    seq_w = s1_pcw + WA_W'(1);
    if (hit) begin
      src   = SRC_TABLE;
      tk    = e_ctr[1];
      nxt_w = tk ? e_tgtw : seq_w;
    end else if (s1_br) begin
      src   = SRC_STATIC;
      tk    = st_back;
      nxt_w = tk ? st_tgtw : seq_w;
    end else begin
      src   = SRC_SEQ;
      tk    = 1'b0;
      nxt_w = seq_w;
    end
  end

  assign pred_valid   = s1_valid;
  assign pred_src     = src;
  assign pred_taken   = tk;
  assign pred_next_pc = {nxt_w, 2'b00};
  assign br_target    = {st_tgtw, 2'b00};

endmodule

// File: rtl/bpred_chk.sv
module bpred_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic [OFF_W-1:0]  fetch_off,
  input logic              pred_valid,
  input logic [ADDR_W-1:0] pred_next_pc,
  input logic              pred_taken,
  input logic [1:0]        pred_src,
  input logic [ADDR_W-1:0] br_target
);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_valid);

  p_aligned_r11: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> (pred_next_pc[1:0] == 2'b00 && br_target[1:0] == 2'b00));

  p_src_legal_r3: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> pred_src != 2'd3);

  p_seq_not_taken_r9: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && pred_src == 2'd0) |-> !pred_taken);

  p_static_dir_r7: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && pred_src == 2'd2) |-> pred_taken == $past(fetch_off[OFF_W-1]));

  p_static_target_r7: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && pred_src == 2'd2 && pred_taken) |-> pred_next_pc == br_target);

  p_fallthrough_r4: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_taken) |->
      pred_next_pc == {$past(fetch_pc[ADDR_W-1:2]) + (ADDR_W-2)'(1), 2'b00});

endmodule

bind branch_tgt_pred bpred_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .fetch_valid  (fetch_valid),
  .fetch_pc     (fetch_pc),
  .fetch_off    (fetch_off),
  .pred_valid   (pred_valid),
  .pred_next_pc (pred_next_pc),
  .pred_taken   (pred_taken),
  .pred_src     (pred_src),
  .br_target    (br_target)
);

// File: tb/branch_tgt_pred_tb_top.sv
`timescale 1ns/1ps
module branch_tgt_pred_tb_top;

  localparam logic [22:0] TAG_A = 23'h00ABC;
  localparam logic [22:0] TAG_B = 23'h5A5A5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0, fetch_is_br = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [23:0] fetch_off = '0;
  logic        rsv_valid = 1'b0, rsv_taken = 1'b0;
  logic [31:0] rsv_pc = '0, rsv_target = '0;
  logic        pred_valid, pred_taken;
  logic [31:0] pred_next_pc, br_target;
  logic [1:0]  pred_src;

  always #2.5 clk = ~clk;

  branch_tgt_pred dut_i (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_is_br(fetch_is_br), .fetch_off(fetch_off),
    .rsv_valid(rsv_valid), .rsv_pc(rsv_pc), .rsv_taken(rsv_taken), .rsv_target(rsv_target),
    .pred_valid(pred_valid), .pred_next_pc(pred_next_pc), .pred_taken(pred_taken),
    .pred_src(pred_src), .br_target(br_target)
  );

  int n_vec = 0;
  int n_err = 0;

  // reference table built from the requirements
  bit          mv   [128];
  logic [22:0] mtag [128];
  logic [1:0]  mctr [128];
  logic [29:0] mtgt [128];

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, result of the fetch checked one edge later
  task automatic step(input string req,
                      input logic fv, input logic [31:0] fpc, input logic fbr, input logic [23:0] foff,
                      input logic rv, input logic [31:0] rpc, input logic rtk, input logic [31:0] rtgt);
    logic [6:0]  idx, ridx;
    logic        hit, e_tk, rhit;
    logic [1:0]  e_src;
    logic [31:0] e_pc, st, pc4;
    fetch_valid = fv; fetch_pc = fpc; fetch_is_br = fbr; fetch_off = foff;
    rsv_valid = rv; rsv_pc = rpc; rsv_taken = rtk; rsv_target = rtgt;
    idx = fpc[8:2];
    hit = mv[idx] && (mtag[idx] == fpc[31:9]);
    pc4 = {fpc[31:2], 2'b00} + 32'd4;
    st  = {fpc[31:2], 2'b00} + 32'd8 + {{6{foff[23]}}, foff, 2'b00};
    if (hit) begin
      e_src = 2'd1; e_tk = mctr[idx][1]; e_pc = e_tk ? {mtgt[idx], 2'b00} : pc4;
    end else if (fbr) begin
      e_src = 2'd2; e_tk = foff[23]; e_pc = e_tk ? st : pc4;
    end else begin
      e_src = 2'd0; e_tk = 1'b0; e_pc = pc4;
    end
    // lookup result above uses the table before this cycle's resolve (R10)
    if (rv) begin
      ridx = rpc[8:2];
      rhit = mv[ridx] && (mtag[ridx] == rpc[31:9]);
      if (rhit) begin
        if (rtk) mctr[ridx] = (mctr[ridx] == 2'd3) ? 2'd3 : mctr[ridx] + 2'd1;
        else     mctr[ridx] = (mctr[ridx] == 2'd0) ? 2'd0 : mctr[ridx] - 2'd1;
      end else begin
        mctr[ridx] = rtk ? 2'd2 : 2'd1;
      end
      mv[ridx] = 1'b1; mtag[ridx] = rpc[31:9]; mtgt[ridx] = rtgt[31:2];
    end
    @(posedge clk);
    @(negedge clk);
    cmp("R2", "pred_valid", {31'd0, pred_valid}, {31'd0, fv});
    if (fv) begin
      cmp(req, "pred_src", {30'd0, pred_src}, {30'd0, e_src});
      cmp(req, "pred_taken", {31'd0, pred_taken}, {31'd0, e_tk});
      cmp(req, "pred_next_pc", pred_next_pc, e_pc);
      cmp("R11", "pc_lsbs", {30'd0, pred_next_pc[1:0]}, 32'd0);
      if (fbr) cmp("R8", "br_target", br_target, st);
    end
  endtask

  function automatic logic [31:0] mkpc(input logic [22:0] t, input int i, input logic [1:0] lo);
    return {t, 7'(i), lo};
  endfunction

  logic [31:0] s_pc  [7];
  logic [23:0] s_off [7];
  bit done = 0;

  initial begin
    for (int i = 0; i < 128; i++) begin mv[i] = 0; mtag[i] = '0; mctr[i] = '0; mtgt[i] = '0; end
    s_pc[0] = 32'h0000_1000; s_off[0] = 24'h000000;
    s_pc[1] = 32'h0000_1000; s_off[1] = 24'h000001;
    s_pc[2] = 32'h0000_1000; s_off[2] = 24'hFFFFFF;
    s_pc[3] = 32'h8000_0000; s_off[3] = 24'h7FFFFF;
    s_pc[4] = 32'h0200_0000; s_off[4] = 24'h800000;
    s_pc[5] = 32'hFFFF_FFFC; s_off[5] = 24'h000001;
    s_pc[6] = 32'h0000_0003; s_off[6] = 24'hFFFFFE;

    // R1: held in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1", "pred_valid in reset", {31'd0, pred_valid}, 32'd0);
    fetch_valid = 1'b1;
    @(negedge clk);
    cmp("R1", "pred_valid in reset with fetch", {31'd0, pred_valid}, 32'd0);
    fetch_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    cmp("R1", "pred_valid after reset", {31'd0, pred_valid}, 32'd0);

    // R1/R9: every index misses after reset, sequential prediction
    for (int i = 0; i < 128; i++)
      step("R9", 1, mkpc(TAG_A, i, 2'(i)), 0, '0, 0, '0, 0, '0);

    // R7/R8: static sign rule and target arithmetic on an empty table
    for (int k = 0; k < 7; k++)
      step("R7", 1, s_pc[k], 1, s_off[k], 0, '0, 0, '0);

    // R2: idle cycle
    step("R2", 0, '0, 0, '0, 0, '0, 0, '0);

    // R5: allocate every index, taken, then look each up
    for (int i = 0; i < 128; i++)
      step("R5", 0, '0, 0, '0, 1, mkpc(TAG_A, i, 2'b01), 1, {8'h40, 8'(i), 16'h1233});
    for (int i = 0; i < 128; i++)
      step("R3", 1, mkpc(TAG_A, i, 2'b00), 0, '0, 0, '0, 0, '0);
    // R3: other tag misses everywhere, falls to static
    for (int i = 0; i < 128; i += 9)
      step("R3", 1, mkpc(TAG_B, i, 2'b00), 1, 24'hFFFFF0, 0, '0, 0, '0);

    // R4: walk a counter down to 0 and back up to 3
    for (int k = 0; k < 3; k++) begin
      step("R4", 0, '0, 0, '0, 1, mkpc(TAG_A, 5, 2'b00), 0, 32'h0000_5550);
      step("R4", 1, mkpc(TAG_A, 5, 2'b00), 0, '0, 0, '0, 0, '0);
    end
    for (int k = 0; k < 4; k++) begin
      step("R4", 0, '0, 0, '0, 1, mkpc(TAG_A, 5, 2'b00), 1, 32'h0000_7770);
      step("R4", 1, mkpc(TAG_A, 5, 2'b00), 0, '0, 0, '0, 0, '0);
    end

    // R6: alias at index 9 replaces, neighbour index 10 unaffected
    step("R6", 0, '0, 0, '0, 1, mkpc(TAG_B, 9, 2'b00), 0, 32'h0001_0000);
    step("R6", 1, mkpc(TAG_A, 9, 2'b00), 1, 24'h000004, 0, '0, 0, '0);
    step("R6", 1, mkpc(TAG_B, 9, 2'b00), 1, 24'hFFFFF0, 0, '0, 0, '0);
    step("R6", 1, mkpc(TAG_A, 10, 2'b00), 0, '0, 0, '0, 0, '0);

    // R10: same-cycle resolve and lookup on one index
    step("R10", 1, mkpc(TAG_A, 20, 2'b00), 0, '0, 1, mkpc(TAG_A, 20, 2'b00), 0, 32'h0000_2000);
    step("R10", 1, mkpc(TAG_A, 20, 2'b00), 0, '0, 1, mkpc(TAG_A, 20, 2'b00), 1, 32'h0000_3000);
    step("R10", 1, mkpc(TAG_A, 20, 2'b00), 0, '0, 0, '0, 0, '0);
    step("R10", 1, mkpc(TAG_B, 30, 2'b00), 1, 24'h000010, 1, mkpc(TAG_B, 30, 2'b00), 1, 32'h0000_4000);
    step("R10", 1, mkpc(TAG_B, 30, 2'b00), 1, 24'h000010, 0, '0, 0, '0);

    // mixed traffic over a small tag pool so entries keep colliding (R4 R5 R6)
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r1, r2, r3;
      r1 = $urandom; r2 = $urandom; r3 = $urandom;
      step("R6", r1[0], {r1[1] ? TAG_A : TAG_B, r1[8:2], r1[10:9]}, r1[11], r2[23:0],
           r1[12], {r1[13] ? TAG_A : TAG_B, 4'b0, r1[16:14], r1[18:17]}, r1[19], r3);
    end

    step("R2", 0, '0, 0, '0, 0, '0, 0, '0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

endmodule